// File: doc/BRIEF.md
# SD/MMC Host Command Path Engine

This block is the command half of an SD/MMC host. Firmware writes a 14-bit control word that holds the command index, the response kind and a set of per-command flags, and sets its enable bit. The engine then builds a 48-bit command frame and shifts it out on the CMD line, most significant bit first. The frame carries the supplied 32-bit argument and a CRC7 that the engine computes itself. If the command expects a reply, the engine watches the line for a start bit, shifts in a 48-bit or 136-bit response, and checks the CRC7 of short responses. Each command ends with exactly one status pulse.

Toward the data path engine, the block issues single-cycle strobes: data-enable, abort, and interrupt-period start and end. It also obeys two inputs from that engine. A busy input refuses new commands. An end-of-data pulse releases a command that was told to wait for it. While a command is in flight, the fields that describe it are locked against firmware writes. The enable bit reads back as 1 until the engine is idle again.

Top module: `sdmmc_cmd_path`

## Requirements
- R1: A started command drives `cmd_oe` high for exactly 48 cycles and shifts out, MSB first, the frame {0, 1, index[5:0], argument[31:0], CRC7, 1}. The CRC7 uses the polynomial x^7+x^3+1 over the first 40 bits, so index 0 with argument 0 gives 48'h400000000095.
- R2: The control word layout is [5:0] index, [7:6] response kind, [8] enable, [9] transfer flag, [10] stop flag, [11] suspend flag, [12] interrupt-wait, [13] pend-wait. While enable reads 1, writes leave index, response kind, enable and the three command flags unchanged; bits 12 and 13 stay writable at all times.
- R3: After reset, `ctl_q` is 0 and the line idles high and undriven. The enable bit is cleared by hardware whenever the engine returns to idle, and it stays 1 while a command is active.
- R4: With the transfer flag set, `data_en` pulses once in the cycle after the end bit. `irq_end` pulses in that same cycle unless the suspend flag is also set.
- R5: With the stop flag set, `abort_o` pulses once in the cycle after the end bit.
- R6: Response kind 01 means a 48-bit response and 11 means a 136-bit response. Kinds 00 and 10 mean no response, and such a command finishes with `cmd_sent`. `resp_q` holds every received bit, with the last received bit at bit 0.
- R7: For a short response, a CRC7 computed over its first 40 bits that matches bits 7..1 gives `resp_ok`; a mismatch gives `crc_fail`. A long response gives `resp_ok` without a check.
- R8: If no start bit (a 0) is seen within TO_CYCLES cycles after the end bit, `rsp_timeout` pulses in the TO_CYCLES-th cycle. A start bit that arrives in the last cycle of that window is still accepted.
- R9: With interrupt-wait set, the response wait has no timeout and the command accepts a short response. Clearing interrupt-wait while waiting returns the engine to idle without any status pulse.
- R10: With pend-wait set and `pend_qual` high, transmission starts only after a `data_end` pulse. With `pend_qual` low, pend-wait has no effect.
- R11: While `dpsm_busy` is high, setting enable starts no command. The enable bit clears and no status pulse occurs.
- R12: The flag bit is bit 0 of the response argument (response bit 8). For a suspend command (suspend=1, transfer=0), a valid response with flag 0 pulses `irq_start`. For a resume command (suspend=1, transfer=1), a valid response with flag 1 pulses `irq_end`.
- R13: Each command that runs to completion produces exactly one of `cmd_sent`, `resp_ok`, `crc_fail` or `rsp_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wd | input | 14 | Control word write data |
| ctl_q | output | 14 | Control word readback |
| cmd_arg | input | 32 | Command argument, sampled when transmission starts |
| dpsm_busy | input | 1 | Data path busy; blocks command start |
| pend_qual | input | 1 | Qualifies pend-wait |
| data_end | input | 1 | End-of-data pulse from the data path |
| cmd_in | input | 1 | CMD line as seen from the card |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line output enable |
| resp_q | output | LONG_LEN | Received response bits |
| cmd_sent | output | 1 | Status: command sent, no response expected |
| resp_ok | output | 1 | Status: response received and accepted |
| crc_fail | output | 1 | Status: short response CRC mismatch |
| rsp_timeout | output | 1 | Status: no response start bit in time |
| data_en | output | 1 | Strobe to the data path: start the transfer |
| abort_o | output | 1 | Strobe to the data path: abort |
| irq_start | output | 1 | Interrupt period start strobe |
| irq_end | output | 1 | Interrupt period end strobe |

## Verification
The bench builds the engine with TO_CYCLES set to 24 and LONG_LEN left at 136. The short timeout window lets the bench probe both edges of the timeout (the last accepted start bit and the first cycle of `rsp_timeout`) exactly. It also lets it show that an interrupt wait outlasts several such windows, all in a few hundred cycles. The full 136-bit long response is captured and compared bit for bit. Frames for index 0 and index 8 are compared against well-known CRC values rather than against a recomputation.

// File: rtl/sdmmc_cmd_path.sv
module sdmmc_cmd_path #(
  parameter int TO_CYCLES = 64,
  parameter int LONG_LEN  = 136
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [13:0]         ctl_wd,
  output logic [13:0]         ctl_q,
  input  logic [31:0]         cmd_arg,
  input  logic                dpsm_busy,
  input  logic                pend_qual,
  input  logic                data_end,
  input  logic                cmd_in,
  output logic                cmd_out,
  output logic                cmd_oe,
  output logic [LONG_LEN-1:0] resp_q,
  output logic                cmd_sent,
  output logic                resp_ok,
  output logic                crc_fail,
  output logic                rsp_timeout,
  output logic                data_en,
  output logic                abort_o,
  output logic                irq_start,
  output logic                irq_end
);
  localparam int FRAME = 48;
  localparam int MX    = (LONG_LEN > TO_CYCLES) ? LONG_LEN : TO_CYCLES;
  localparam int CW    = $clog2(MX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_SEND, S_WAIT, S_RECV} st_t;
  st_t st;

  logic [5:0]          idx;
  logic [1:0]          rkind;
  logic                go, xfer, stop, susp, irqw, pendw, irq_m;
  logic [FRAME-1:0]    sh;
  logic [CW-1:0]       cnt;
  logic [LONG_LEN-1:0] rnext;
  logic [FRAME-1:0]    frame_c;
  logic                need_wait, is_long, crc_ok;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  assign ctl_q     = {pendw, irqw, susp, stop, xfer, go, rkind, idx};
  assign need_wait = rkind[0] | irqw;
  assign is_long   = (rkind == 2'b11);
  assign frame_c   = {2'b01, idx, cmd_arg, crc7({2'b01, idx, cmd_arg}), 1'b1};
  assign rnext     = {resp_q[LONG_LEN-2:0], cmd_in};
  assign crc_ok    = (crc7(rnext[47:8]) == rnext[7:1]);
  assign cmd_oe    = (st == S_SEND);
  assign cmd_out   = (st == S_SEND) ? sh[FRAME-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {idx, rkind, go, xfer, stop, susp, irqw, pendw, irq_m} <= '0;
      sh <= '0;
      cnt <= '0;
      resp_q <= '0;
      {cmd_sent, resp_ok, crc_fail, rsp_timeout} <= '0;
      {data_en, abort_o, irq_start, irq_end} <= '0;
    end else begin
      {cmd_sent, resp_ok, crc_fail, rsp_timeout} <= '0;
      {data_en, abort_o, irq_start, irq_end} <= '0;
      if (ctl_we) begin
        if (!go) begin
          idx   <= ctl_wd[5:0];
          rkind <= ctl_wd[7:6];
          go    <= ctl_wd[8];
          xfer  <= ctl_wd[9];
          stop  <= ctl_wd[10];
          susp  <= ctl_wd[11];
        end
        irqw  <= ctl_wd[12];
        pendw <= ctl_wd[13];
      end
      case (st)
        S_IDLE: if (go) begin
          if (dpsm_busy) go <= 1'b0;
          else if (pendw && pend_qual) st <= S_PEND;
          else begin
            st  <= S_SEND;
            sh  <= frame_c;
            cnt <= '0;
          end
        end
        S_PEND: if (data_end) begin
          st  <= S_SEND;
          sh  <= frame_c;
          cnt <= '0;
        end
        S_SEND: begin
          sh  <= {sh[FRAME-2:0], 1'b0};
          cnt <= cnt + CW'(1);
          if (cnt == CW'(FRAME - 1)) begin
            data_en <= xfer;
            abort_o <= stop;
            irq_end <= xfer & ~susp;
            if (need_wait) begin
              st    <= S_WAIT;
              cnt   <= '0;
              irq_m <= irqw;
            end else begin
              st       <= S_IDLE;
              go       <= 1'b0;
              cmd_sent <= 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (irq_m && !irqw) begin
            st <= S_IDLE;
            go <= 1'b0;
          end else if (!cmd_in) begin
            st     <= S_RECV;
            resp_q <= '0;
            cnt    <= CW'(1);
          end else if (!irq_m && cnt == CW'(TO_CYCLES - 1)) begin
            st          <= S_IDLE;
            go          <= 1'b0;
            rsp_timeout <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_RECV: begin
          resp_q <= rnext;
          cnt    <= cnt + CW'(1);
          if (cnt == (is_long ? CW'(LONG_LEN - 1) : CW'(FRAME - 1))) begin
            st <= S_IDLE;
            go <= 1'b0;
            if (is_long) resp_ok <= 1'b1;
            else if (crc_ok) begin
              resp_ok   <= 1'b1;
              irq_start <= susp & ~xfer & ~rnext[8];
              irq_end   <= susp & xfer & rnext[8];
            end else crc_fail <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go) |-> $stable({idx, rkind, xfer, stop, susp}));

  p_active_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> go);

  p_status_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sent | resp_ok | crc_fail | rsp_timeout) |-> (st == S_IDLE && !go));

  p_strobe_after_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en | abort_o) |-> $past(st == S_SEND));

  p_no_timeout_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> !$past(irq_m));

  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && !data_end) |=> (st == S_PEND));

  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && go && dpsm_busy) |=> (!go && !cmd_oe));

  p_one_status_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_sent, resp_ok, crc_fail, rsp_timeout}) <= 1);
endmodule

// File: tb/test_sdmmc_cmd_path.sv
module test_sdmmc_cmd_path;
  localparam int TO = 24;
  localparam int LL = 136;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, dpsm_busy = 1'b0, pend_qual = 1'b0, data_end = 1'b0, cmd_in = 1'b1;
  logic [13:0] ctl_wd = '0, ctl_q;
  logic [31:0] cmd_arg = '0;
  logic cmd_out, cmd_oe, cmd_sent, resp_ok, crc_fail, rsp_timeout;
  logic data_en, abort_o, irq_start, irq_end;
  logic [LL-1:0] resp_q;

  int errors = 0, checks = 0;
  int n_sent, n_ok, n_crc, n_to, n_den, n_abt, n_is, n_ie, tx_n;
  logic [47:0] tx;

  always #2 clk = ~clk;

  sdmmc_cmd_path #(.TO_CYCLES(TO), .LONG_LEN(LL)) i_sdmmc_cmd_path (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd), .ctl_q(ctl_q),
    .cmd_arg(cmd_arg), .dpsm_busy(dpsm_busy), .pend_qual(pend_qual), .data_end(data_end),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .resp_q(resp_q),
    .cmd_sent(cmd_sent), .resp_ok(resp_ok), .crc_fail(crc_fail), .rsp_timeout(rsp_timeout),
    .data_en(data_en), .abort_o(abort_o), .irq_start(irq_start), .irq_end(irq_end));

  always @(posedge clk) if (rst_n) begin
    n_sent += int'(cmd_sent); n_ok += int'(resp_ok); n_crc += int'(crc_fail);
    n_to += int'(rsp_timeout); n_den += int'(data_en); n_abt += int'(abort_o);
    n_is += int'(irq_start); n_ie += int'(irq_end);
    if (cmd_oe) begin tx = {tx[46:0], cmd_out}; tx_n++; end
  end

  function automatic logic [6:0] bcrc(input logic [39:0] d);
    logic [46:0] v;
    v = {d, 7'b0};
    for (int i = 46; i >= 7; i--) if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  function automatic logic [13:0] mk(input logic pw, iw, sp, st, xf, g,
                                     input logic [1:0] rk, input logic [5:0] ix);
    return {pw, iw, sp, st, xf, g, rk, ix};
  endfunction

  function automatic logic [47:0] mk_rsp(input logic [5:0] ix, input logic [31:0] a);
    return {2'b00, ix, a, bcrc({2'b00, ix, a}), 1'b1};
  endfunction

  task automatic check(input string req, input string what, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    n_sent = 0; n_ok = 0; n_crc = 0; n_to = 0; n_den = 0; n_abt = 0; n_is = 0; n_ie = 0;
    tx_n = 0; tx = '0;
  endtask

  task automatic wr(input logic [13:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wd = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic start(input logic [13:0] v, input logic [31:0] a);
    cmd_arg = a; clr(); wr(v);
  endtask

  task automatic wait_sent();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx_n == 48 && !cmd_oe) break;
    end
  endtask

  task automatic finish_cmd();
    for (int i = 0; i < 600; i++) begin
      if (!ctl_q[8]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_resp(input logic [135:0] bits, input int len);
    for (int i = len - 1; i >= 0; i--) begin cmd_in = bits[i]; @(negedge clk); end
    cmd_in = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic t_reset();
    check("R3", "ctl_q after reset", ctl_q, 0);
    check("R3", "line idle", {cmd_oe, cmd_out}, 2'b01);
    check("R3", "resp_q after reset", resp_q, 0);
  endtask

  task automatic t_cmd0();
    start(mk(0, 0, 0, 0, 0, 1, 2'b00, 6'd0), 32'h0);
    wait_sent(); finish_cmd();
    check("R1", "frame index 0", tx, 48'h400000000095);
    check("R1", "bits driven", tx_n, 48);
    check("R6", "cmd_sent for kind 00", n_sent, 1);
    check("R13", "other status", n_ok + n_crc + n_to, 0);
    check("R3", "enable cleared", ctl_q[8], 0);
  endtask

  task automatic t_flags();
    start(mk(0, 0, 0, 1, 1, 1, 2'b10, 6'd8), 32'h1AA);
    wait_sent(); finish_cmd();
    check("R1", "frame index 8", tx, 48'h48000001AA87);
    check("R4", "data_en pulses", n_den, 1);
    check("R4", "irq_end pulses", n_ie, 1);
    check("R5", "abort pulses", n_abt, 1);
    check("R6", "cmd_sent for kind 10", n_sent, 1);
  endtask

  task automatic t_short(input logic bad);
    logic [47:0] r;
    r = mk_rsp(6'd17, 32'hCAFE1234);
    if (bad) r[3] = ~r[3];
    start(mk(0, 0, 0, 0, 0, 1, 2'b01, 6'd17), 32'h1234);
    wait_sent();
    check("R1", "frame with own crc", tx, {2'b01, 6'd17, 32'h1234, bcrc({2'b01, 6'd17, 32'h1234}), 1'b1});
    drive_resp({88'h0, r}, 48); finish_cmd();
    check("R6", "short response captured", resp_q, {88'h0, r});
    check("R7", "resp_ok count", n_ok, bad ? 0 : 1);
    check("R7", "crc_fail count", n_crc, bad ? 1 : 0);
    check("R13", "no cmd_sent", n_sent + n_to, 0);
  endtask

  task automatic t_long();
    logic [135:0] p;
    p = {8'h3F, 128'h0123456789ABCDEFFEDCBA9876543210};
    start(mk(0, 0, 0, 0, 0, 1, 2'b11, 6'd2), 32'h0);
    wait_sent(); drive_resp(p, 136); finish_cmd();
    check("R6", "long response captured", resp_q, p);
    check("R7", "long resp_ok", n_ok, 1);
    check("R13", "long single status", n_crc + n_to + n_sent, 0);
  endtask

  task automatic t_timeout();
    start(mk(0, 0, 0, 0, 0, 1, 2'b01, 6'd13), 32'h0);
    wait_sent();
    for (int k = 1; k <= TO; k++) begin
      @(negedge clk);
      if (k == TO - 1) check("R8", "no timeout one cycle early", rsp_timeout, 0);
      if (k == TO) check("R8", "timeout at window end", rsp_timeout, 1);
    end
    finish_cmd();
    check("R8", "timeout count", n_to, 1);
    check("R13", "timeout only status", n_ok + n_crc + n_sent, 0);
    check("R3", "enable cleared after timeout", ctl_q[8], 0);
  endtask

  task automatic t_late_start();
    start(mk(0, 0, 0, 0, 0, 1, 2'b01, 6'd9), 32'h0);
    wait_sent();
    repeat (TO - 1) @(negedge clk);
    drive_resp({88'h0, mk_rsp(6'd9, 32'h55)}, 48); finish_cmd();
    check("R8", "last-cycle start accepted", n_ok, 1);
    check("R8", "no timeout", n_to, 0);
  endtask

  task automatic t_irq_wait();
    start(mk(0, 1, 0, 0, 0, 1, 2'b00, 6'd40), 32'h0);
    wait_sent();
    repeat (3 * TO) @(negedge clk);
    check("R9", "no timeout in interrupt wait", n_to, 0);
    check("R9", "still enabled", ctl_q[8], 1);
    drive_resp({88'h0, mk_rsp(6'd40, 32'h7)}, 48); finish_cmd();
    check("R9", "interrupt response ok", n_ok, 1);
    wr(14'h0);
  endtask

  task automatic t_irq_abort();
    start(mk(0, 1, 0, 0, 0, 1, 2'b01, 6'd40), 32'h0);
    wait_sent();
    repeat (5) @(negedge clk);
    wr(mk(0, 0, 0, 0, 0, 1, 2'b01, 6'd40));
    finish_cmd();
    check("R9", "abort clears enable", ctl_q[8], 0);
    check("R9", "abort gives no status", n_sent + n_ok + n_crc + n_to, 0);
  endtask

  task automatic t_lock();
    start(mk(0, 0, 0, 0, 0, 1, 2'b00, 6'd5), 32'hA5);
    repeat (10) @(negedge clk);
    wr(mk(0, 0, 1, 1, 1, 1, 2'b01, 6'd33));
    wait_sent(); finish_cmd();
    check("R2", "index locked", ctl_q[5:0], 5);
    check("R2", "kind and flags locked", ctl_q[11:9], 0);
    check("R2", "kind locked", ctl_q[7:6], 0);
    check("R2", "frame keeps index", tx[45:40], 5);
    check("R2", "no locked flag effect", n_den + n_abt, 0);
    wr(mk(0, 0, 0, 0, 0, 0, 2'b01, 6'd33));
    check("R2", "write accepted when idle", ctl_q, mk(0, 0, 0, 0, 0, 0, 2'b01, 6'd33));
    wr(14'h0);
  endtask

  task automatic t_busy();
    dpsm_busy = 1'b1;
    start(mk(0, 0, 0, 0, 0, 1, 2'b00, 6'd1), 32'h0);
    repeat (8) @(negedge clk);
    check("R11", "enable cleared while busy", ctl_q[8], 0);
    check("R11", "nothing driven", tx_n, 0);
    check("R11", "no status", n_sent + n_ok + n_crc + n_to, 0);
    dpsm_busy = 1'b0;
  endtask

  task automatic t_pend();
    pend_qual = 1'b1;
    start(mk(1, 0, 0, 0, 0, 1, 2'b00, 6'd3), 32'h0);
    repeat (20) @(negedge clk);
    check("R10", "held before data_end", tx_n, 0);
    check("R10", "enabled while held", ctl_q[8], 1);
    data_end = 1'b1; @(negedge clk); data_end = 1'b0;
    wait_sent(); finish_cmd();
    check("R10", "sent after data_end", n_sent, 1);
    pend_qual = 1'b0;
    start(mk(1, 0, 0, 0, 0, 1, 2'b00, 6'd3), 32'h0);
    wait_sent(); finish_cmd();
    check("R10", "unqualified pend-wait ignored", tx_n, 48);
    wr(14'h0);
  endtask

  task automatic t_suspend(input logic xf, input logic flag);
    start(mk(0, 0, 1, 0, xf, 1, 2'b01, 6'd52), 32'h0);
    wait_sent();
    drive_resp({88'h0, mk_rsp(6'd52, {31'h0, flag})}, 48); finish_cmd();
    check("R12", "irq_start", n_is, (!xf && !flag) ? 1 : 0);
    check("R12", "irq_end", n_ie, (xf && flag) ? 1 : 0);
    check("R4", "data_en on resume", n_den, xf ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd0();
    t_flags();
    t_short(1'b0);
    t_short(1'b1);
    t_long();
    t_timeout();
    t_late_start();
    t_irq_wait();
    t_irq_abort();
    t_lock();
    t_busy();
    t_pend();
    t_suspend(1'b0, 1'b0);
    t_suspend(1'b0, 1'b1);
    t_suspend(1'b1, 1'b1);
    summary();
    $finish;
  end
endmodule